// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Overflow Flag

This block is a purely combinational arithmetic-logic unit. It takes two N-bit operands and a 3-bit operation code. It returns an N-bit result, the carry out of its adder and an overflow flag, which a processor's exception logic can consume.

Every arithmetic operation runs through one ripple adder. A subtract passes operand B through an inverting mux and forces the adder's carry input high, so it computes A plus the two's complement of B. The overflow flag means different things for different operations. In unsigned forms it is the adder carry. In signed forms it fires when both adder inputs have the same sign and the sum's sign differs from them. Logic operations, bitwise NOT and the signed comparison never raise it.

Top module: `alu_ovf`

## Requirements
- R1: Code 000 returns A AND B bit by bit, and overflow is 0.
- R2: Code 001 returns A OR B bit by bit, and overflow is 0.
- R3: Code 101 returns the bitwise complement of A, and overflow is 0.
- R4: Code 010 (signed add) returns (A+B) mod 2^N. Overflow is 1 exactly when the signed sum of A and B falls outside the N-bit two's-complement range.
- R5: Code 011 (signed subtract) returns (A-B) mod 2^N, computed as A + ~B + 1. Overflow is 1 exactly when the signed difference falls outside the N-bit two's-complement range, which is the same as applying the sign rule to A, ~B and the result.
- R6: Code 110 (unsigned add) returns (A+B) mod 2^N, and overflow equals the carry out.
- R7: Code 111 (unsigned subtract) returns (A-B) mod 2^N, and overflow equals the carry out. The carry out is 1 exactly when A >= B as unsigned values.
- R8: Code 100 (set-less-than) returns 1 in bit 0 when A < B as signed values and 0 otherwise, with every other bit 0 and overflow 0.
- R9: The carry out is always the adder's carry. The adder adds A + ~B + 1 for codes 011, 100 and 111, and A + B for every other code.
- R10: A signed add whose operands differ in their top bit never raises overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | N | Operand A |
| b | input | N | Operand B |
| op | input | 3 | Operation code |
| result | output | N | Operation result |
| cout | output | 1 | Carry out of the shared adder |
| ovf | output | 1 | Overflow flag |

## Verification
There is no register anywhere in the block, so all three outputs are due in the same cycle as the operands and operation code that produce them. The bench applies a new operand/code combination just after each rising clock edge and compares result, carry and overflow at the following falling edge, once the logic has settled. The bench sweeps every code against every operand pair at N=4. A behavioural integer model computes the expected results in the same cycle.

// File: rtl/alu_ovf.sv
module alu_ovf #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [2:0]   op,
  output logic [N-1:0] result,
  output logic         cout,
  output logic         ovf
);
  localparam logic [2:0] OP_AND  = 3'b000;
  localparam logic [2:0] OP_OR   = 3'b001;
  localparam logic [2:0] OP_ADDS = 3'b010;
  localparam logic [2:0] OP_SUBS = 3'b011;
  localparam logic [2:0] OP_SLT  = 3'b100;
  localparam logic [2:0] OP_NOTA = 3'b101;
  localparam logic [2:0] OP_ADDU = 3'b110;
  localparam logic [2:0] OP_SUBU = 3'b111;
  localparam int MSB = N - 1;

  logic         invert_b;
  logic [N-1:0] b_eff;
  logic [N:0]   sum;
  logic [N-1:0] r;
  logic         sovf;

  assign invert_b = (op[1] & op[0]) | (op == OP_SLT);
  assign b_eff    = invert_b ? ~b : b;
  assign sum      = {1'b0, a} + {1'b0, b_eff} + {{N{1'b0}}, invert_b};
  assign r        = sum[N-1:0];
  assign cout     = sum[N];
  assign sovf     = (a[MSB] & b_eff[MSB] & ~r[MSB]) | (~a[MSB] & ~b_eff[MSB] & r[MSB]);

  always_comb begin
    result = r;
    ovf    = 1'b0;
    case (op)
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_NOTA: result = ~a;
      OP_SLT:  result = {{(N-1){1'b0}}, r[MSB] ^ sovf};
      OP_ADDS, OP_SUBS: ovf = sovf;
      OP_ADDU, OP_SUBU: ovf = cout;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_ovf_chk.sv
module alu_ovf_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic [2:0]   op,
  input logic [N-1:0] result,
  input logic         cout,
  input logic         ovf
);
  always_comb begin
    if (op == 3'b000 || op == 3'b001 || op == 3'b101)
      AST_LOGIC_NO_OVF: assert (!ovf) else $error("logic op raised overflow"); // R1
    if (op == 3'b100)
      AST_SLT_SHAPE: assert (result[N-1:1] == '0 && !ovf) else $error("slt shape"); // R8
    if (op[2] && op[1])
      AST_UNS_OVF_CARRY: assert (ovf == cout) else $error("unsigned ovf"); // R6
    if (op == 3'b010 && (a[N-1] != b[N-1]))
      AST_MIXED_ADD_SAFE: assert (!ovf) else $error("mixed add ovf"); // R10
    if (op == 3'b011 && (a[N-1] == b[N-1]))
      AST_SAME_SUB_SAFE: assert (!ovf) else $error("same-sign sub ovf"); // R5
  end
endmodule

bind alu_ovf alu_ovf_chk #(.N(N)) chk_i (
  .a(a), .b(b), .op(op), .result(result), .cout(cout), .ovf(ovf)
);

// File: tb/alu_ovf_tb_top.sv
`timescale 1ns/1ps
module alu_ovf_tb_top;
  localparam int N = 4;
  localparam int MASK = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] a = '0, b = '0;
  logic [2:0] op = 3'b000;
  logic [N-1:0] result;
  logic cout, ovf;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu_ovf #(.N(N)) dut_i (
    .a(a), .b(b), .op(op), .result(result), .cout(cout), .ovf(ovf)
  );

  function automatic string tag_of(input int code);
    case (code)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R8";
      5: return "R3";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic int sval(input int v);
    return (v >= (1 << (N-1))) ? v - (1 << N) : v;
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (op=%0d a=%0d b=%0d)",
               tag, what, act, exp, op, a, b);
    end
  endtask

  task automatic run_vec(input int code, input int ua, input int ub);
    int sa, sb, sum, er, ec, eo, lo, hi, t;
    @(posedge clk); #1;
    op = code[2:0]; a = ua[N-1:0]; b = ub[N-1:0];
    sa = sval(ua); sb = sval(ub);
    lo = -(1 << (N-1)); hi = (1 << (N-1)) - 1;
    if (code == 3 || code == 4 || code == 7) sum = ua + ((~ub) & MASK) + 1;
    else sum = ua + ub;
    ec = (sum >> N) & 1;
    er = sum & MASK;
    eo = 0;
    case (code)
      0: er = ua & ub;
      1: er = ua | ub;
      5: er = (~ua) & MASK;
      2: begin t = sa + sb; eo = (t < lo || t > hi) ? 1 : 0; end
      3: begin t = sa - sb; eo = (t < lo || t > hi) ? 1 : 0; end
      4: er = (sa < sb) ? 1 : 0;
      6, 7: eo = ec;
      default: ;
    endcase
    @(negedge clk);
    check(tag_of(code), int'(result), er, "result");
    check(tag_of(code), int'(ovf), eo, "ovf");
    check("R9", int'(cout), ec, "cout");
    if (code == 2 && ((ua ^ ub) >> (N-1)) != 0)
      check("R10", int'(ovf), 0, "mixed-sign add ovf");
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(result), 0, "idle result");
    check("R1", int'(ovf), 0, "idle ovf");
    check("R9", int'(cout), 0, "idle cout");
    for (int c = 0; c < 8; c++)
      for (int x = 0; x <= MASK; x++)
        for (int y = 0; y <= MASK; y++)
          run_vec(c, x, y);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule